// File: doc/BRIEF.md
# Two-Input Fuzzy Risk Classifier

This block is a synchronous fixed-point fuzzy inference engine of the Mamdani type. It takes two crisp 8-bit levels, a measured level and a derived level, and returns one crisp 8-bit risk score. It also returns a 3-bit code for the dominant output term. The measured level is graded against five triangular terms. The derived level is graded against five bell-shaped terms, which are held in per-term lookup memories filled at elaboration. Five rules pair equal linguistic levels of the two inputs. The rule outputs are clipped and combined by maximum. A centre-of-gravity stage then sweeps a sampled output universe and divides with a sequential restoring divider.

A request is a single-cycle `in_valid` with both levels present. The engine raises `busy` and ignores further requests until the result appears. It presents the result with a one-cycle `out_valid`. The result values hold until the next result. Term breakpoints, the bell width and the number of output samples are parameters.

Top module: `fuzzy_risk_classifier`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_score`, `out_class` and `out_nofire` are all 0.
- R2: The measured-level grade of term k (k = 0..4, centre c = 64k) is floor(t*255/64), where t = 64 - |x - c|. The grade is 0 when t <= 0.
- R3: The derived-level grade of term k is floor(255*A*A / (A*A + (x - 64k)^2)), where A is the bell width parameter (default 32).
- R4: Rule k has strength min(measured grade k, derived grade k). Only equal-level pairs form rules.
- R5: The output set is sampled at 32 points y_i = floor(i*255/31). At each point its value is the maximum over k of min(strength k, triangular grade of term k at y_i), using the R2 shape.
- R6: `out_score` = floor(sum(y_i*mu_i) / sum(mu_i)) over the 32 samples.
- R7: When the sum of mu_i is 0, `out_score` is 0 and `out_nofire` is 1. Otherwise `out_nofire` is 0.
- R8: `out_class` is the index k of the largest rule strength. The codes are 0 normal, 1 low, 2 medium, 3 high and 4 very high. A tie goes to the lower index.
- R9: `out_valid` is a one-cycle pulse exactly 56 clock edges after the edge that accepts `in_valid`. `busy` is 1 from the accepting edge until the result edge and is 0 while `out_valid` is 1. The result outputs hold between pulses.
- R10: An `in_valid` while `busy` is 1 has no effect. It neither changes the pending result nor produces an extra one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, taken when idle |
| in_meas | input | 8 | Measured level, triangular terms |
| in_der | input | 8 | Derived level, bell terms |
| busy | output | 1 | Engine is working on a request |
| out_valid | output | 1 | One-cycle result strobe |
| out_score | output | 8 | Crisp risk score |
| out_class | output | 3 | Dominant output term code |
| out_nofire | output | 1 | No rule fired (zero weight sum) |

## Verification
All four results (score, class, no-fire flag and the strobe) are due on the 56th edge after the accepting edge. The breakdown is one edge for the memory read, one for the rule minimum, 32 for the sweep, 21 for the divider and one to register the outputs. The bench counts edges from acceptance, samples one nanosecond after each edge, and checks that the strobe arrives on exactly that count before it compares any value. For the ignored-request case, a second request is inserted during the sweep. The bench then checks that the first request's values arrive on time and that no strobe follows within the next 70 cycles.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int N_TERMS = 5;

  typedef enum logic [1:0] {T_IDLE, T_LOOK, T_RULE, T_RUN} top_state_t;
  typedef enum logic [1:0] {C_IDLE, C_SWEEP, C_DIV, C_DONE} cog_state_t;

  // triangle centred on k<<shift with half-width 1<<shift, peak gmax
  function automatic int tri_grade(int x, int k, int shift, int gmax);
    int d;
    int t;
    d = x - (k << shift);
    if (d < 0) d = -d;
    t = (1 << shift) - d;
    if (t <= 0) return 0;
    return (t * gmax) >> shift;
  endfunction

  // first-order bell on the same centres, half-height at distance a
  function automatic int bell_grade(int x, int k, int shift, int a, int gmax);
    int d;
    d = x - (k << shift);
    return (gmax * a * a) / (a * a + d * d);
  endfunction

  function automatic int sample_point(int i, int npts, int xmax);
    return (i * xmax) / (npts - 1);
  endfunction
endpackage

// File: rtl/fz_tri_fuzz.sv
module fz_tri_fuzz
  import fz_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int G_W   = 8,
  parameter int SHIFT = 6
) (
  input  logic [IN_W-1:0]              x,
  output logic [N_TERMS-1:0][G_W-1:0]  grade
);
  localparam int GMAX = (1 << G_W) - 1;

  always_comb begin
    for (int k = 0; k < N_TERMS; k++) begin
      grade[k] = G_W'(tri_grade(int'(x), k, SHIFT, GMAX));
    end
  end
endmodule

// File: rtl/fz_bell_rom.sv
module fz_bell_rom
  import fz_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int G_W    = 8,
  parameter int TERM   = 0,
  parameter int SHIFT  = 6,
  parameter int BELL_A = 32
) (
  input  logic            clk,
  input  logic [IN_W-1:0] addr,
  output logic [G_W-1:0]  q
);
  localparam int DEPTH = 1 << IN_W;
  localparam int GMAX  = (1 << G_W) - 1;

  logic [G_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = G_W'(bell_grade(i, TERM, SHIFT, BELL_A, GMAX));
    end
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/fz_cog.sv
module fz_cog
  import fz_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int G_W   = 8,
  parameter int NPTS  = 32,
  parameter int SHIFT = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [N_TERMS-1:0][G_W-1:0] strength,
  output logic                        finishing,
  output logic                        done_q,
  output logic [IN_W-1:0]             score_q,
  output logic                        nofire_q
);
  localparam int GMAX   = (1 << G_W) - 1;
  localparam int XMAX   = (1 << IN_W) - 1;
  localparam int NUM_W  = $clog2(NPTS * XMAX * GMAX + 1);
  localparam int DEN_W  = $clog2(NPTS * GMAX + 1);
  localparam int IDX_W  = $clog2(NPTS);
  localparam int CNT_W  = $clog2(NUM_W);
  localparam int PROD_W = IN_W + G_W;

  cog_state_t         st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_W-1:0]   num_q;
  logic [DEN_W-1:0]   den_q;
  logic [DEN_W-1:0]   rem_q;
  logic [IN_W-1:0]    quo_q;

  logic [IN_W-1:0]    y_w;
  logic [G_W-1:0]     mu_w;
  logic [G_W-1:0]     og_t;
  logic [G_W-1:0]     clip_t;
  logic [PROD_W-1:0]  prod_w;
  logic [DEN_W:0]     sh_w;
  logic               ge_w;

  // output set value at the current sample point
  always_comb begin
    y_w  = IN_W'(sample_point(int'(idx_q), NPTS, XMAX));
    mu_w = '0;
    og_t = '0;
    clip_t = '0;
    for (int k = 0; k < N_TERMS; k++) begin
      og_t   = G_W'(tri_grade(int'(y_w), k, SHIFT, GMAX));
      clip_t = (strength[k] < og_t) ? strength[k] : og_t;
      if (clip_t > mu_w) mu_w = clip_t;
    end
  end

  assign prod_w = PROD_W'(y_w) * PROD_W'(mu_w);

  // restoring division step: dividend bits leave num_q from the top
  assign sh_w = {rem_q, num_q[NUM_W-1]};
  assign ge_w = (sh_w >= {1'b0, den_q});

  assign finishing = (st_q == C_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= C_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      num_q    <= '0;
      den_q    <= '0;
      rem_q    <= '0;
      quo_q    <= '0;
      done_q   <= 1'b0;
      score_q  <= '0;
      nofire_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        C_IDLE: begin
          if (start) begin
            idx_q <= '0;
            num_q <= '0;
            den_q <= '0;
            st_q  <= C_SWEEP;
          end
        end
        C_SWEEP: begin
          num_q <= num_q + NUM_W'(prod_w);
          den_q <= den_q + DEN_W'(mu_w);
          if (idx_q == IDX_W'(NPTS - 1)) begin
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
            st_q  <= C_DIV;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        C_DIV: begin
          rem_q <= ge_w ? DEN_W'(sh_w - {1'b0, den_q}) : sh_w[DEN_W-1:0];
          quo_q <= {quo_q[IN_W-2:0], ge_w};
          num_q <= {num_q[NUM_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(NUM_W - 1)) st_q <= C_DONE;
        end
        C_DONE: begin
          done_q   <= 1'b1;
          nofire_q <= (den_q == '0);
          score_q  <= (den_q == '0) ? '0 : quo_q;
          st_q     <= C_IDLE;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuzzy_risk_classifier.sv
module fuzzy_risk_classifier
  import fz_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int G_W       = 8,
  parameter int TRI_SHIFT = 6,
  parameter int BELL_A    = 32,
  parameter int NPTS      = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_meas,
  input  logic [IN_W-1:0] in_der,
  output logic            busy,
  output logic            out_valid,
  output logic [IN_W-1:0] out_score,
  output logic [2:0]      out_class,
  output logic            out_nofire
);
  top_state_t                  st_q;
  logic [IN_W-1:0]             meas_q;
  logic [IN_W-1:0]             der_q;
  logic [N_TERMS-1:0][G_W-1:0] tri_w;
  logic [N_TERMS-1:0][G_W-1:0] tri_q;
  logic [G_W-1:0]              bell_w [N_TERMS];
  logic [N_TERMS-1:0][G_W-1:0] str_q;
  logic [2:0]                  cls_w;
  logic [G_W-1:0]              best_w;
  logic [2:0]                  class_q;
  logic                        cog_fin;

  fz_tri_fuzz #(.IN_W(IN_W), .G_W(G_W), .SHIFT(TRI_SHIFT)) u_tri (
    .x     (meas_q),
    .grade (tri_w)
  );

  for (genvar k = 0; k < N_TERMS; k++) begin : g_bell
    fz_bell_rom #(
      .IN_W(IN_W), .G_W(G_W), .TERM(k), .SHIFT(TRI_SHIFT), .BELL_A(BELL_A)
    ) u_rom (
      .clk  (clk),
      .addr (der_q),
      .q    (bell_w[k])
    );
  end

  fz_cog #(.IN_W(IN_W), .G_W(G_W), .NPTS(NPTS), .SHIFT(TRI_SHIFT)) u_cog (
    .clk       (clk),
    .rst       (rst),
    .start     (st_q == T_RULE),
    .strength  (str_q),
    .finishing (cog_fin),
    .done_q    (out_valid),
    .score_q   (out_score),
    .nofire_q  (out_nofire)
  );

  // dominant term: strict compare keeps the lower index on ties
  always_comb begin
    cls_w  = '0;
    best_w = str_q[0];
    for (int k = 1; k < N_TERMS; k++) begin
      if (str_q[k] > best_w) begin
        best_w = str_q[k];
        cls_w  = 3'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= T_IDLE;
      meas_q  <= '0;
      der_q   <= '0;
      tri_q   <= '0;
      str_q   <= '0;
      class_q <= '0;
    end else begin
      case (st_q)
        T_IDLE: begin
          if (in_valid) begin
            meas_q <= in_meas;
            der_q  <= in_der;
            st_q   <= T_LOOK;
          end
        end
        T_LOOK: begin
          tri_q <= tri_w;
          st_q  <= T_RULE;
        end
        T_RULE: begin
          for (int k = 0; k < N_TERMS; k++) begin
            str_q[k] <= (tri_q[k] < bell_w[k]) ? tri_q[k] : bell_w[k];
          end
          st_q <= T_RUN;
        end
        T_RUN: begin
          if (cog_fin) begin
            class_q <= cls_w;
            st_q    <= T_IDLE;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != T_IDLE);
  assign out_class = class_q;
endmodule

// File: rtl/fz_chk.sv
module fz_chk #(
  parameter int IN_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            out_valid,
  input logic [IN_W-1:0] out_score,
  input logic [2:0]      out_class,
  input logic            out_nofire
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_score) && $stable(out_class) && $stable(out_nofire)));

  // R7
  nofire_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nofire) |-> (out_score == '0));

  // R8
  class_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_class <= 3'd4));
endmodule

bind fuzzy_risk_classifier fz_chk #(.IN_W(IN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_score  (out_score),
  .out_class  (out_class),
  .out_nofire (out_nofire)
);

// File: tb/fuzzy_risk_classifier_tb.sv
`timescale 1ns/1ps
module fuzzy_risk_classifier_tb;
  localparam int LAT  = 56;
  localparam int A_WIDE = 32;
  localparam int A_NARROW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_meas = '0;
  logic [7:0] in_der = '0;

  logic a_busy, a_valid, a_nofire;
  logic [7:0] a_score;
  logic [2:0] a_class;
  logic n_busy, n_valid, n_nofire;
  logic [7:0] n_score;
  logic [2:0] n_class;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fuzzy_risk_classifier #(.BELL_A(A_WIDE)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_meas(in_meas), .in_der(in_der),
    .busy(a_busy), .out_valid(a_valid), .out_score(a_score), .out_class(a_class),
    .out_nofire(a_nofire)
  );

  fuzzy_risk_classifier #(.BELL_A(A_NARROW)) u_dut_nf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_meas(in_meas), .in_der(in_der),
    .busy(n_busy), .out_valid(n_valid), .out_score(n_score), .out_class(n_class),
    .out_nofire(n_nofire)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_tri(int x, int k);
    int d = x - 64 * k;
    int t;
    if (d < 0) d = -d;
    t = 64 - d;
    return (t > 0) ? (t * 255) / 64 : 0;
  endfunction

  function automatic int m_bell(int x, int k, int a);
    int d = x - 64 * k;
    return (255 * a * a) / (a * a + d * d);
  endfunction

  task automatic model(input int m, input int d, input int a,
                       output int sc, output int cl, output int nf);
    int s [5];
    int num = 0;
    int den = 0;
    int best;
    for (int k = 0; k < 5; k++) begin
      int g1 = m_tri(m, k);
      int g2 = m_bell(d, k, a);
      s[k] = (g1 < g2) ? g1 : g2;
    end
    for (int i = 0; i < 32; i++) begin
      int y = (i * 255) / 31;
      int mu = 0;
      for (int k = 0; k < 5; k++) begin
        int o = m_tri(y, k);
        int c = (s[k] < o) ? s[k] : o;
        if (c > mu) mu = c;
      end
      num += y * mu;
      den += mu;
    end
    nf = (den == 0) ? 1 : 0;
    sc = (den == 0) ? 0 : num / den;
    cl = 0;
    best = s[0];
    for (int k = 1; k < 5; k++) begin
      if (s[k] > best) begin
        best = s[k];
        cl = k;
      end
    end
  endtask

  task automatic run_case(int m, int d, bit intrude, string tag);
    int sa, ca, fa, sn, cn, fn;
    int lat = 0;
    int extra = 0;
    model(m, d, A_WIDE, sa, ca, fa);
    model(m, d, A_NARROW, sn, cn, fn);
    @(negedge clk);
    in_valid = 1'b1;
    in_meas = 8'(m);
    in_der = 8'(d);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R9", "busy after accept", int'(a_busy), 1);
    for (int c = 1; c <= 120; c++) begin
      if (intrude && c == 10) begin
        in_valid = 1'b1;
        in_meas = ~in_meas;
        in_der = ~in_der;
      end
      if (intrude && c == 11) in_valid = 1'b0;
      @(posedge clk); #1;
      if (a_valid) begin
        lat = c;
        break;
      end
    end
    check("R9", "result latency", lat, LAT);
    check("R9", "narrow instance strobe", int'(n_valid), 1);
    check({"R6 ", tag}, "score wide bell", int'(a_score), sa);
    check({"R6 ", tag}, "score narrow bell", int'(n_score), sn);
    check("R8", "class wide bell", int'(a_class), ca);
    check("R8", "class narrow bell", int'(n_class), cn);
    check("R7", "nofire wide bell", int'(a_nofire), fa);
    check("R7", "nofire narrow bell", int'(n_nofire), fn);
    @(posedge clk); #1;
    check("R9", "strobe one cycle", int'(a_valid), 0);
    if (intrude) begin
      for (int c = 0; c < 70; c++) begin
        @(posedge clk); #1;
        if (a_valid || n_valid) extra++;
      end
      check("R10", "extra results after ignored request", extra, 0);
      check("R10", "busy after ignored request", int'(a_busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1701);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "busy", int'(a_busy), 0);
    check("R1", "out_valid", int'(a_valid), 0);
    check("R1", "out_score", int'(a_score), 0);
    check("R1", "out_class", int'(a_class), 0);
    check("R1", "out_nofire", int'(a_nofire), 0);

    run_case(0, 0, 0, "R2");
    run_case(40, 40, 0, "R2");
    run_case(128, 0, 0, "R3");
    run_case(96, 96, 0, "R4");
    run_case(255, 255, 0, "R5");
    run_case(200, 30, 0, "R4");
    // narrow bell: rule 0 derived grade is 0, no rule fires there
    run_case(0, 128, 0, "R7");
    run_case(160, 100, 1, "R10");
    for (int i = 0; i < 40; i++) begin
      int m = int'($urandom_range(0, 255));
      int d = ($urandom_range(0, 3) == 0) ? m : int'($urandom_range(0, 255));
      run_case(m, d, 0, "R5");
    end
    run_case(64, 200, 1, "R10");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule